// File: doc/BRIEF.md
# Age-Ordered Wakeup and Issue Queue

This block is the scheduling window of an out-of-order core. Up to two hardware threads dispatch one instruction per cycle into a pool of 16 slots. Each instruction carries a thread id, a 16-bit sequence number, an op class, up to two source physical-register tags and an optional destination tag. It may also carry a flag that marks it non-speculative.

A register scoreboard and a completion broadcast decide when each source is available. Among the ready slots, the queue first finds the oldest one in each op class. It then lets the class heads compete by sequence number, and grants up to `ISSUE_W` instructions per cycle. An issued instruction keeps its slot until a commit covers it or a squash removes it. Occupancy is reported for each thread and for the whole queue.

Each slot is a four-state machine:
- `SL_FREE`: the slot holds nothing.
- `SL_WAIT`: the slot holds an instruction whose operands or release are outstanding.
- `SL_READY`: the instruction may be selected.
- `SL_ISSUED`: the instruction has been granted and waits for retirement.

The transitions are:
- alloc-ready (`SL_FREE` to `SL_READY`)
- alloc-wait (`SL_FREE` to `SL_WAIT`)
- operands-complete (`SL_WAIT` to `SL_READY`)
- grant (`SL_READY` to `SL_ISSUED`)
- kill (any occupied state to `SL_FREE`, on a commit or a squash that covers the entry)

A kill takes priority over a grant in the same cycle.

Top module: `age_issue_queue`

## Requirements
- R1: After reset, no lane issues, `total_free` is 16, every thread's `thr_free` is 8, and no full flag is set. Every scoreboard bit reads ready after reset.
- R2: Physical tags 0–95 are integer registers and tags 96–191 are floating-point registers, and one scoreboard covers both ranges. Timing of a dispatch with every source ready (scoreboard set, or source unused) and no hold:
  - It is accepted at the clock edge that ends its dispatch cycle.
  - It is offered on an issue lane in the very next cycle.
  - It moves to `SL_ISSUED` at the following edge.
- R3: A `wake_valid` pulse on tag T sets the scoreboard bit for T. It also marks source T of every waiting consumer ready. A consumer whose sources are then all ready is offered for issue in the next cycle. A consumer dispatched in the same cycle as the wake of its source treats that source as ready.
- R4: Within one op class, the ready entry with the smallest sequence number is the head. Across classes, lane 0 takes the head with the smallest sequence number. After a head is taken, its class competes with its next-oldest ready entry.
- R5: At most `ISSUE_W` (2) instructions issue per cycle, and lanes fill from lane 0 upward. If both lanes are valid, the sequence number on lane 0 is not larger than the one on lane 1.
- R6: An instruction dispatched with `disp_nonspec`=1 is not offered for issue until `rel_valid` arrives with a `rel_seq` equal to its own sequence number. A release carrying any other number leaves it held.
- R7: A commit (`cmt_valid`, `cmt_tid`, `cmt_seq`) frees every slot of that thread whose sequence number is at most `cmt_seq`. It frees the slot whatever its state, and it leaves the other thread's slots untouched.
- R8: A squash (`sq_valid`, `sq_tid`, `sq_seq`) frees every slot of that thread whose sequence number is larger than `sq_seq`, including slots that have already issued. A ready entry hit by the squash is not offered on any lane in the squash cycle.
- R9: Occupancy is counted per thread against a cap of 8:
  - `thr_free[t]` is 8 minus the occupied slots of thread t, and `thr_full[t]` is set when that count reaches 0.
  - A dispatch to a full thread is dropped.
  - `total_free` is 16 minus all occupied slots, and `total_full` is set when `total_free` is 0.
  - In the flattened per-thread buses, thread t occupies bits [t*5 +: 5] of `thr_free` and bit t of `thr_full`.
- R10: An accepted dispatch with a destination clears that tag's scoreboard bit. Consumers dispatched afterwards that name the tag wait until a wake on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tid | input | 1 | Thread of the dispatched instruction |
| disp_seq | input | 16 | Sequence number of the dispatched instruction |
| disp_cls | input | 2 | Op class |
| disp_src0_valid | input | 1 | First source is used |
| disp_src0 | input | 8 | First source physical tag |
| disp_src1_valid | input | 1 | Second source is used |
| disp_src1 | input | 8 | Second source physical tag |
| disp_dst_valid | input | 1 | Instruction writes a destination |
| disp_dst | input | 8 | Destination physical tag |
| disp_nonspec | input | 1 | Hold until a matching release arrives |
| wake_valid | input | 1 | Completion broadcast |
| wake_tag | input | 8 | Tag being produced |
| rel_valid | input | 1 | Non-speculative release |
| rel_seq | input | 16 | Sequence number being released |
| cmt_valid | input | 1 | Commit request |
| cmt_tid | input | 1 | Committing thread |
| cmt_seq | input | 16 | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 1 | Squashed thread |
| sq_seq | input | 16 | Entries younger than this are removed |
| issue_valid | output | 2 | Lane valid bits, lane 0 oldest |
| issue_tid | output | 2 | Thread per lane, 1 bit each |
| issue_seq | output | 32 | Sequence number per lane, 16 bits each |
| issue_cls | output | 4 | Op class per lane, 2 bits each |
| thr_free | output | 10 | Free slots per thread, 5 bits each |
| thr_full | output | 2 | Per-thread full flags |
| total_free | output | 5 | Free slots in the whole queue |
| total_full | output | 1 | Whole queue full |

## Verification
The assertions check four properties in every cycle:
- Lane ordering and packing.
- That no lane ever offers an entry that a same-cycle squash removes, or one that a same-cycle commit retires.
- That each thread's free count stays within its cap.
- That `total_full` agrees with `total_free`.

Other behaviour is only visible across a sequence of cycles, so only the bench's scenarios can show it:
- Oldest-first selection across classes.
- The operand wait on a cleared tag, and the same-cycle wake case.
- Holding a non-speculative entry against a wrong release.
- Dropping a dispatch to a full thread.
- Squash removing an already-issued entry.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
    typedef enum logic [1:0] {
        SL_FREE   = 2'd0,
        SL_WAIT   = 2'd1,
        SL_READY  = 2'd2,
        SL_ISSUED = 2'd3
    } slot_state_e;
endpackage

// File: rtl/iq_oldest_pick.sv
`timescale 1ns/1ps
// Finds the candidate with the smallest sequence number; ties go to the lower index.
module iq_oldest_pick #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       cand,
    input  logic [N*SEQ_W-1:0] seqs,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || seqs[i*SEQ_W +: SEQ_W] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = seqs[i*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/iq_slot.sv
`timescale 1ns/1ps
// One queue slot: payload, operand readiness, hold flag and the slot state machine.
module iq_slot
    import iq_pkg::*;
#(
    parameter int TID_W = 1,
    parameter int SEQ_W = 16,
    parameter int CLS_W = 2,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [TID_W-1:0] a_tid,
    input  logic [SEQ_W-1:0] a_seq,
    input  logic [CLS_W-1:0] a_cls,
    input  logic [TAG_W-1:0] a_tag0,
    input  logic [TAG_W-1:0] a_tag1,
    input  logic             a_rdy0,
    input  logic             a_rdy1,
    input  logic             a_nonspec,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             cmt_valid,
    input  logic [TID_W-1:0] cmt_tid,
    input  logic [SEQ_W-1:0] cmt_seq,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             grant,
    output slot_state_e      state,
    output logic [TID_W-1:0] tid,
    output logic [SEQ_W-1:0] seq,
    output logic [CLS_W-1:0] cls,
    output logic             eligible
);
    slot_state_e      st_q, st_n;
    logic [TAG_W-1:0] tag0_q, tag1_q;
    logic             rdy0_q, rdy1_q, hold_q;
    logic             rdy0_n, rdy1_n, hold_n;
    logic             kill;

    always_comb begin
        rdy0_n = rdy0_q | (wake_valid && wake_tag == tag0_q);
        rdy1_n = rdy1_q | (wake_valid && wake_tag == tag1_q);
        hold_n = hold_q & ~(rel_valid && rel_seq == seq);
        kill   = (st_q != SL_FREE) &&
                 ((cmt_valid && cmt_tid == tid && seq <= cmt_seq) ||
                  (sq_valid  && sq_tid  == tid && seq >  sq_seq));
    end

    // next-state process
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SL_FREE: begin
                if (alloc)
                    st_n = (a_rdy0 && a_rdy1 && !a_nonspec) ? SL_READY : SL_WAIT;
            end
            SL_WAIT: begin
                if (kill)
                    st_n = SL_FREE;
                else if (rdy0_n && rdy1_n && !hold_n)
                    st_n = SL_READY;
            end
            SL_READY: begin
                if (kill)
                    st_n = SL_FREE;
                else if (grant)
                    st_n = SL_ISSUED;
            end
            SL_ISSUED: begin
                if (kill)
                    st_n = SL_FREE;
            end
            default: st_n = SL_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_FREE;
        else        st_q <= st_n;
    end

    // payload and operand subscriptions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tid    <= '0;
            seq    <= '0;
            cls    <= '0;
            tag0_q <= '0;
            tag1_q <= '0;
            rdy0_q <= 1'b0;
            rdy1_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (st_q == SL_FREE && alloc) begin
            tid    <= a_tid;
            seq    <= a_seq;
            cls    <= a_cls;
            tag0_q <= a_tag0;
            tag1_q <= a_tag1;
            rdy0_q <= a_rdy0;
            rdy1_q <= a_rdy1;
            hold_q <= a_nonspec;
        end else begin
            rdy0_q <= rdy0_n;
            rdy1_q <= rdy1_n;
            hold_q <= hold_n;
        end
    end

    // output process
    always_comb begin
        state    = st_q;
        eligible = (st_q == SL_READY) && !kill;
    end
endmodule

// File: rtl/age_issue_queue.sv
`timescale 1ns/1ps
module age_issue_queue
    import iq_pkg::*;
#(
    parameter int ENTRIES        = 16,
    parameter int THREADS        = 2,
    parameter int MAX_PER_THREAD = ENTRIES / THREADS,
    parameter int SEQ_W          = 16,
    parameter int NUM_CLASSES    = 4,
    parameter int ISSUE_W        = 2,
    parameter int NUM_INT_REGS   = 96,
    parameter int NUM_FP_REGS    = 96,
    // derived widths
    parameter int NUM_PREGS      = NUM_INT_REGS + NUM_FP_REGS,
    parameter int TAG_W          = $clog2(NUM_PREGS),
    parameter int TID_W          = (THREADS > 1) ? $clog2(THREADS) : 1,
    parameter int CLS_W          = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    parameter int CNT_W          = $clog2(ENTRIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [TID_W-1:0]         disp_tid,
    input  logic [SEQ_W-1:0]         disp_seq,
    input  logic [CLS_W-1:0]         disp_cls,
    input  logic                     disp_src0_valid,
    input  logic [TAG_W-1:0]         disp_src0,
    input  logic                     disp_src1_valid,
    input  logic [TAG_W-1:0]         disp_src1,
    input  logic                     disp_dst_valid,
    input  logic [TAG_W-1:0]         disp_dst,
    input  logic                     disp_nonspec,
    input  logic                     wake_valid,
    input  logic [TAG_W-1:0]         wake_tag,
    input  logic                     rel_valid,
    input  logic [SEQ_W-1:0]         rel_seq,
    input  logic                     cmt_valid,
    input  logic [TID_W-1:0]         cmt_tid,
    input  logic [SEQ_W-1:0]         cmt_seq,
    input  logic                     sq_valid,
    input  logic [TID_W-1:0]         sq_tid,
    input  logic [SEQ_W-1:0]         sq_seq,
    output logic [ISSUE_W-1:0]       issue_valid,
    output logic [ISSUE_W*TID_W-1:0] issue_tid,
    output logic [ISSUE_W*SEQ_W-1:0] issue_seq,
    output logic [ISSUE_W*CLS_W-1:0] issue_cls,
    output logic [THREADS*CNT_W-1:0] thr_free,
    output logic [THREADS-1:0]       thr_full,
    output logic [CNT_W-1:0]         total_free,
    output logic                     total_full
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CIDX_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1;

    // ---------------- register scoreboard ----------------
    logic [NUM_PREGS-1:0] sb_q;
    logic                 accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q <= '1;
        end else begin
            if (wake_valid && wake_tag < TAG_W'(NUM_PREGS))
                sb_q[wake_tag] <= 1'b1;
            if (accept && disp_dst_valid && disp_dst < TAG_W'(NUM_PREGS))
                sb_q[disp_dst] <= 1'b0;
        end
    end

    logic src0_rdy, src1_rdy;
    always_comb begin
        src0_rdy = !disp_src0_valid || sb_q[disp_src0] || (wake_valid && wake_tag == disp_src0);
        src1_rdy = !disp_src1_valid || sb_q[disp_src1] || (wake_valid && wake_tag == disp_src1);
    end

    // ---------------- slot array ----------------
    slot_state_e          slot_st  [ENTRIES];
    logic [TID_W-1:0]     slot_tid [ENTRIES];
    logic [SEQ_W-1:0]     slot_seq [ENTRIES];
    logic [CLS_W-1:0]     slot_cls [ENTRIES];
    logic [ENTRIES-1:0]   elig;
    logic [ENTRIES-1:0]   grant;
    logic [ENTRIES*SEQ_W-1:0] seq_flat;

    // ---------------- occupancy ----------------
    logic [CNT_W-1:0] occ_thr [THREADS];
    logic [CNT_W-1:0] occ_all;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        occ_all  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int t = 0; t < THREADS; t++) occ_thr[t] = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_st[i] == SL_FREE) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end else begin
                occ_all = occ_all + 1'b1;
                for (int t = 0; t < THREADS; t++)
                    if (slot_tid[i] == TID_W'(t)) occ_thr[t] = occ_thr[t] + 1'b1;
            end
        end
    end

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            thr_free[t*CNT_W +: CNT_W] = CNT_W'(MAX_PER_THREAD) - occ_thr[t];
            thr_full[t]                = (occ_thr[t] >= CNT_W'(MAX_PER_THREAD));
        end
        total_free = CNT_W'(ENTRIES) - occ_all;
        total_full = (occ_all == CNT_W'(ENTRIES));
    end

    assign accept = disp_valid && free_any && !thr_full[disp_tid];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        iq_slot #(
            .TID_W(TID_W), .SEQ_W(SEQ_W), .CLS_W(CLS_W), .TAG_W(TAG_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (accept && free_idx == IDX_W'(i)),
            .a_tid      (disp_tid),
            .a_seq      (disp_seq),
            .a_cls      (disp_cls),
            .a_tag0     (disp_src0),
            .a_tag1     (disp_src1),
            .a_rdy0     (src0_rdy),
            .a_rdy1     (src1_rdy),
            .a_nonspec  (disp_nonspec),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .rel_valid  (rel_valid),
            .rel_seq    (rel_seq),
            .cmt_valid  (cmt_valid),
            .cmt_tid    (cmt_tid),
            .cmt_seq    (cmt_seq),
            .sq_valid   (sq_valid),
            .sq_tid     (sq_tid),
            .sq_seq     (sq_seq),
            .grant      (grant[i]),
            .state      (slot_st[i]),
            .tid        (slot_tid[i]),
            .seq        (slot_seq[i]),
            .cls        (slot_cls[i]),
            .eligible   (elig[i])
        );
        assign seq_flat[i*SEQ_W +: SEQ_W] = slot_seq[i];
    end

    // ---------------- select: per-class heads, then oldest head ----------------
    logic [ENTRIES-1:0] taken [ISSUE_W+1];
    assign taken[0] = '0;

    for (genvar r = 0; r < ISSUE_W; r++) begin : g_lane
        logic [NUM_CLASSES-1:0]       hfound;
        logic [NUM_CLASSES*SEQ_W-1:0] hseq;
        logic [NUM_CLASSES*IDX_W-1:0] hidx;
        logic                         gfound;
        logic [CIDX_W-1:0]            cidx;
        logic [IDX_W-1:0]             gidx;

        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            logic [ENTRIES-1:0] cand;
            logic [IDX_W-1:0]   cix;
            always_comb begin
                for (int i = 0; i < ENTRIES; i++)
                    cand[i] = elig[i] && !taken[r][i] && slot_cls[i] == CLS_W'(c);
            end
            iq_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_head (
                .cand  (cand),
                .seqs  (seq_flat),
                .found (hfound[c]),
                .idx   (cix)
            );
            assign hidx[c*IDX_W +: IDX_W] = cix;
            assign hseq[c*SEQ_W +: SEQ_W] = slot_seq[cix];
        end

        iq_oldest_pick #(.N(NUM_CLASSES), .SEQ_W(SEQ_W), .IDX_W(CIDX_W)) u_age (
            .cand  (hfound),
            .seqs  (hseq),
            .found (gfound),
            .idx   (cidx)
        );

        assign gidx = hidx[cidx*IDX_W +: IDX_W];
        assign taken[r+1] = taken[r] | (gfound ? (ENTRIES'(1) << gidx) : '0);

        assign issue_valid[r]               = gfound;
        assign issue_tid[r*TID_W +: TID_W]  = gfound ? slot_tid[gidx] : '0;
        assign issue_seq[r*SEQ_W +: SEQ_W]  = gfound ? slot_seq[gidx] : '0;
        assign issue_cls[r*CLS_W +: CLS_W]  = gfound ? slot_cls[gidx] : '0;
    end

    assign grant = taken[ISSUE_W];
endmodule

// File: rtl/iq_checker.sv
`timescale 1ns/1ps
module iq_checker #(
    parameter int ISSUE_W        = 2,
    parameter int SEQ_W          = 16,
    parameter int TID_W          = 1,
    parameter int THREADS        = 2,
    parameter int CNT_W          = 5,
    parameter int MAX_PER_THREAD = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sq_valid,
    input logic [TID_W-1:0]         sq_tid,
    input logic [SEQ_W-1:0]         sq_seq,
    input logic                     cmt_valid,
    input logic [TID_W-1:0]         cmt_tid,
    input logic [SEQ_W-1:0]         cmt_seq,
    input logic [ISSUE_W-1:0]       issue_valid,
    input logic [ISSUE_W*TID_W-1:0] issue_tid,
    input logic [ISSUE_W*SEQ_W-1:0] issue_seq,
    input logic [THREADS*CNT_W-1:0] thr_free,
    input logic [CNT_W-1:0]         total_free,
    input logic                     total_full
);
    p_full_matches_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        total_full == (total_free == '0));

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        p_thread_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            thr_free[t*CNT_W +: CNT_W] <= CNT_W'(MAX_PER_THREAD));
    end

    for (genvar r = 0; r < ISSUE_W; r++) begin : g_lane
        p_no_squashed_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid && issue_valid[r] && issue_tid[r*TID_W +: TID_W] == sq_tid)
            |-> issue_seq[r*SEQ_W +: SEQ_W] <= sq_seq);

        p_no_committed_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmt_valid && issue_valid[r] && issue_tid[r*TID_W +: TID_W] == cmt_tid)
            |-> issue_seq[r*SEQ_W +: SEQ_W] > cmt_seq);

        if (r > 0) begin : g_ord
            p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
                issue_valid[r] |-> (issue_valid[r-1] &&
                    issue_seq[(r-1)*SEQ_W +: SEQ_W] <= issue_seq[r*SEQ_W +: SEQ_W]));
        end
    end
endmodule

bind age_issue_queue iq_checker #(
    .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .TID_W(TID_W), .THREADS(THREADS),
    .CNT_W(CNT_W), .MAX_PER_THREAD(MAX_PER_THREAD)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_seq(issue_seq),
    .thr_free(thr_free), .total_free(total_free), .total_full(total_full)
);

// File: tb/age_issue_queue_test.sv
`timescale 1ns/1ps
module age_issue_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid, disp_tid, disp_src0_valid, disp_src1_valid, disp_dst_valid, disp_nonspec;
    logic [15:0] disp_seq;
    logic [1:0]  disp_cls;
    logic [7:0]  disp_src0, disp_src1, disp_dst;
    logic        wake_valid, rel_valid, cmt_valid, cmt_tid, sq_valid, sq_tid;
    logic [7:0]  wake_tag;
    logic [15:0] rel_seq, cmt_seq, sq_seq;
    logic [1:0]  issue_valid, issue_tid, thr_full;
    logic [31:0] issue_seq;
    logic [3:0]  issue_cls;
    logic [9:0]  thr_free;
    logic [4:0]  total_free;
    logic        total_full;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    age_issue_queue uut (.*);

    always #2.5 clk = ~clk;

    localparam int NV = 6;
    localparam int TV_SEQ [NV] = '{27, 21, 35, 24, 30, 22};
    localparam int TV_CLS [NV] = '{0, 1, 2, 1, 3, 0};
    localparam int EXP_ORD[NV] = '{21, 22, 24, 27, 30, 35};

    task automatic idle();
        disp_valid = 0; disp_tid = 0; disp_seq = 0; disp_cls = 0;
        disp_src0_valid = 0; disp_src0 = 0; disp_src1_valid = 0; disp_src1 = 0;
        disp_dst_valid = 0; disp_dst = 0; disp_nonspec = 0;
        wake_valid = 0; wake_tag = 0; rel_valid = 0; rel_seq = 0;
        cmt_valid = 0; cmt_tid = 0; cmt_seq = 0; sq_valid = 0; sq_tid = 0; sq_seq = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic disp(input int tid, input int seq, input int cls,
                        input int s0v, input int s0, input int s1v, input int s1,
                        input int dv, input int d, input int ns);
        disp_valid = 1; disp_tid = 1'(tid); disp_seq = 16'(seq); disp_cls = 2'(cls);
        disp_src0_valid = 1'(s0v); disp_src0 = 8'(s0);
        disp_src1_valid = 1'(s1v); disp_src1 = 8'(s1);
        disp_dst_valid = 1'(dv); disp_dst = 8'(d); disp_nonspec = 1'(ns);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        cmt_valid = 1; cmt_tid = 0; cmt_seq = 16'hFFFF; tick();
        cmt_valid = 1; cmt_tid = 1; cmt_seq = 16'hFFFF; tick();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 total_free", int'(total_free), 16);
        chk("R1 thr_free t0", int'(thr_free[4:0]), 8);
        chk("R1 thr_free t1", int'(thr_free[9:5]), 8);
        chk("R1 full flags", int'({total_full, thr_full}), 0);

        // R4/R5/R10 table: producer clears tag 40, consumers wait, wake releases all
        disp(0, 10, 0, 0, 0, 0, 0, 1, 40, 0); tick();
        chk("R2 producer offered", int'(issue_seq[15:0]), 10);
        for (int k = 0; k < NV; k++) begin
            disp(0, TV_SEQ[k], TV_CLS[k], 1, 40, 0, 0, 0, 0, 0); tick();
            chk("R10 consumer waits", int'(issue_valid), 0);
        end
        wake_valid = 1; wake_tag = 40; tick();
        for (int c = 0; c < NV / 2; c++) begin
            chk("R5 both lanes", int'(issue_valid), 3);
            chk("R4 lane0 oldest", int'(issue_seq[15:0]), EXP_ORD[2*c]);
            chk("R4 lane1 next", int'(issue_seq[31:16]), EXP_ORD[2*c+1]);
            tick();
        end
        chk("R5 drained", int'(issue_valid), 0);
        chk("R9 issued still held", int'(thr_free[4:0]), 1);
        clear_all();
        chk("R7 commit frees all", int'(thr_free[4:0]), 8);

        // R3 same-cycle wake at dispatch
        disp(0, 50, 1, 0, 0, 0, 0, 1, 60, 0); tick();
        chk("R3 producer", int'(issue_seq[15:0]), 50);
        disp(0, 51, 2, 1, 60, 0, 0, 0, 0, 0); wake_valid = 1; wake_tag = 60; tick();
        chk("R3 same-cycle wake valid", int'(issue_valid), 1);
        chk("R3 same-cycle wake seq", int'(issue_seq[15:0]), 51);
        tick(); clear_all();

        // R2 floating-point tag wait, reset-ready tag 7
        disp(1, 60, 3, 1, 7, 0, 0, 1, 150, 0); tick();
        chk("R2 reset-ready source", int'(issue_seq[15:0]), 60);
        chk("R2 thread on lane", int'(issue_tid[0]), 1);
        disp(1, 61, 0, 0, 0, 1, 150, 0, 0, 0); tick();
        chk("R10 fp tag wait", int'(issue_valid), 0);
        tick();
        chk("R10 fp tag still waits", int'(issue_valid), 0);
        wake_valid = 1; wake_tag = 150; tick();
        chk("R3 wake fp consumer", int'(issue_seq[15:0]), 61);
        tick(); clear_all();

        // R6 non-speculative hold
        disp(0, 70, 1, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R6 held", int'(issue_valid), 0);
        rel_valid = 1; rel_seq = 71; tick();
        chk("R6 wrong release", int'(issue_valid), 0);
        rel_valid = 1; rel_seq = 70; tick();
        chk("R6 released", int'(issue_seq[15:0]), 70);
        tick(); clear_all();

        // R7 selective commit
        disp(1, 80, 0, 0, 0, 0, 0, 0, 0, 0); tick();
        disp(1, 81, 0, 0, 0, 0, 0, 0, 0, 0); tick();
        disp(1, 82, 0, 0, 0, 0, 0, 0, 0, 0); tick();
        disp(0, 83, 1, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R7 t1 before", int'(thr_free[9:5]), 5);
        cmt_valid = 1; cmt_tid = 1; cmt_seq = 81; tick();
        chk("R7 t1 after commit", int'(thr_free[9:5]), 7);
        chk("R7 t0 untouched", int'(thr_free[4:0]), 7);
        cmt_valid = 1; cmt_tid = 0; cmt_seq = 82; tick();
        chk("R7 younger kept", int'(thr_free[4:0]), 7);
        rel_valid = 1; rel_seq = 83; tick();
        chk("R7 kept entry issues", int'(issue_seq[15:0]), 83);
        tick(); clear_all();

        // R8 squash
        disp(0, 89, 0, 0, 0, 0, 0, 0, 0, 0); tick();
        disp(0, 90, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        disp(0, 91, 1, 0, 0, 0, 0, 0, 0, 1); tick();
        disp(0, 92, 2, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R8 before squash", int'(thr_free[4:0]), 4);
        sq_valid = 1; sq_tid = 0; sq_seq = 90; tick();
        chk("R8 younger removed", int'(thr_free[4:0]), 6);
        rel_valid = 1; rel_seq = 91; tick();
        chk("R8 squashed not issued", int'(issue_valid), 0);
        rel_valid = 1; rel_seq = 90; tick();
        chk("R8 survivor issues", int'(issue_seq[15:0]), 90);
        tick();
        sq_valid = 1; sq_tid = 0; sq_seq = 88; tick();
        chk("R8 issued entries removed", int'(thr_free[4:0]), 8);
        disp(0, 95, 3, 0, 0, 0, 0, 0, 0, 0); tick();
        chk("R8 ready before squash", int'(issue_valid), 1);
        sq_valid = 1; sq_tid = 0; sq_seq = 94; #1;
        chk("R8 masked in squash cycle", int'(issue_valid), 0);
        tick();
        chk("R8 ready entry removed", int'(thr_free[4:0]), 8);

        // R9 per-thread cap and drop
        for (int k = 0; k < 8; k++) begin
            disp(1, 100 + k, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        end
        chk("R9 t1 full", int'(thr_full), 2);
        chk("R9 t1 free zero", int'(thr_free[9:5]), 0);
        chk("R9 total half", int'(total_free), 8);
        disp(1, 108, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R9 drop keeps count", int'(total_free), 8);
        rel_valid = 1; rel_seq = 108; tick();
        chk("R9 dropped never issues", int'(issue_valid), 0);
        for (int k = 0; k < 8; k++) begin
            disp(0, 110 + k, 1, 0, 0, 0, 0, 0, 0, 1); tick();
        end
        chk("R9 total full", int'(total_full), 1);
        chk("R9 total free zero", int'(total_free), 0);
        clear_all();
        chk("R9 emptied", int'(total_free), 16);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule